// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Collector

This block gathers the eight interrupt causes of a two-channel serial controller into one 8-bit status word. It combines that word with a software-written enable mask to drive one active-low interrupt request line. Its inputs are of three kinds. Some are conditions that the status simply follows: the transmit and receive fill-level conditions of each channel. Some are single-cycle events that latch a status bit: a break starting or ending on each channel, the counter reaching its terminal point, and edges on four general input pins. The rest are clear strobes that drop a latched bit: a break-change acknowledge per channel, the counter stop command, and the side-effect read of the pin-change register.

The mask decides only whether a status bit can pull the request line low. Software always reads the true, unmasked status through a small register port, which selects either the mask or the status word. Only the mask can be written.

Top module: `sio_irq_hub`

## Requirements
- R1: While `rst` is high at a clock edge, the status word and the mask both become 0x00, and `irq_n` is high afterwards.
- R2: Status bit 0 (`tx_lvl_a`), bit 1 (`rx_lvl_a`), bit 4 (`tx_lvl_b`) and bit 5 (`rx_lvl_b`) take the value their input had at the previous clock edge.
- R3: Status bit 2 (channel A) and bit 6 (channel B) are set by a one-cycle pulse on `brk_evt_a` or `brk_evt_b`. They stay set until that same channel's `brk_clr_a` or `brk_clr_b` is seen at an edge. The other channel's acknowledge has no effect on them.
- R4: Status bit 3 is set by `ctr_tick` and stays set until `ctr_stop` is seen at an edge.
- R5: Status bit 7 is set when any `pin_chg[i]` pulses while `pin_en[i]` is 1. A pin edge whose enable bit is 0 is ignored. The bit clears when `pin_rd` is seen at an edge.
- R6: When the set event and the clear strobe of a latched bit (bit 2, 3, 6 or 7) occur in the same cycle, the bit ends up set.
- R7: `irq_n` is low exactly when some status bit and the mask bit in the same position are both 1. A status bit whose mask bit is 0 has no effect on `irq_n`.
- R8: With `reg_sel` = 1, `reg_rdata` returns the full unmasked status word, whatever the mask holds. With `reg_sel` = 0, it returns the mask.
- R9: `reg_wr` with `reg_sel` = 0 loads `reg_wdata` into the mask at the clock edge. `reg_wr` with `reg_sel` = 1 changes neither the mask nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_lvl_a | input | 1 | Channel A transmit level condition |
| rx_lvl_a | input | 1 | Channel A receive level or timeout condition |
| tx_lvl_b | input | 1 | Channel B transmit level condition |
| rx_lvl_b | input | 1 | Channel B receive level or timeout condition |
| brk_evt_a | input | 1 | Channel A break start/end pulse |
| brk_evt_b | input | 1 | Channel B break start/end pulse |
| brk_clr_a | input | 1 | Channel A break-change acknowledge |
| brk_clr_b | input | 1 | Channel B break-change acknowledge |
| ctr_tick | input | 1 | Counter ready pulse |
| ctr_stop | input | 1 | Counter stop command |
| pin_chg | input | 4 | Per-pin change pulses |
| pin_en | input | 4 | Per-pin change interrupt enables |
| pin_rd | input | 1 | Pin-change register read strobe |
| reg_sel | input | 1 | 0 selects the mask, 1 selects the status |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two things can meet in the same cycle here: a latched bit's set event and its clear strobe. This can happen for a break change and its acknowledge, a counter tick and the stop command, or an enabled pin edge and the pin-register read. The bench first clears each bit, then drives both strobes on the same edge and requires the bit to read back as 1. A second overlap involves a mask write and status activity. The bench changes the mask while status bits are held, and judges `irq_n` on the cycle after the write against the new mask, not the old one.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    localparam int STAT_W = 8;
    localparam int PIN_N  = 4;

    // Bit positions of the status word
    localparam int B_TX_A  = 0;
    localparam int B_RX_A  = 1;
    localparam int B_BRK_A = 2;
    localparam int B_CTR   = 3;
    localparam int B_TX_B  = 4;
    localparam int B_RX_B  = 5;
    localparam int B_BRK_B = 6;
    localparam int B_PIN   = 7;

    typedef enum logic {
        SEL_MASK = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [STAT_W-1:0] lvl;
        logic [STAT_W-1:0] set;
        logic [STAT_W-1:0] clr;
    } src_vec_t;

    // Latched (sticky) positions; all others follow a level
    function automatic bit is_sticky(input int idx);
        return (idx == B_BRK_A) || (idx == B_CTR) ||
               (idx == B_BRK_B) || (idx == B_PIN);
    endfunction

endpackage

// File: rtl/sio_irq_cell.sv
module sio_irq_cell #(
    parameter bit STICKY = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic set,
    input  logic clr,
    output logic q
);
    generate
        if (STICKY) begin : g_sticky
            // set outranks clear so no event is dropped
            always_ff @(posedge clk) begin
                if (rst)      q <= 1'b0;
                else if (set) q <= 1'b1;
                else if (clr) q <= 1'b0;
            end
            logic unused_lvl;
            assign unused_lvl = lvl;
        end else begin : g_level
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= lvl;
            end
            logic unused_sc;
            assign unused_sc = set ^ clr;
        end
    endgenerate
endmodule

// File: rtl/sio_irq_mask.sv
module sio_irq_mask
    import sio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wdata,
    input  logic [STAT_W-1:0] stat,
    output logic [STAT_W-1:0] mask_q,
    output logic              irq_n
);
    always_ff @(posedge clk) begin
        if (rst)        mask_q <= '0;
        else if (wr_en) mask_q <= wdata;
    end

    assign irq_n = ~|(stat & mask_q);
endmodule

// File: rtl/sio_irq_hub.sv
module sio_irq_hub
    import sio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_lvl_a,
    input  logic              rx_lvl_a,
    input  logic              tx_lvl_b,
    input  logic              rx_lvl_b,
    input  logic              brk_evt_a,
    input  logic              brk_evt_b,
    input  logic              brk_clr_a,
    input  logic              brk_clr_b,
    input  logic              ctr_tick,
    input  logic              ctr_stop,
    input  logic [PIN_N-1:0]  pin_chg,
    input  logic [PIN_N-1:0]  pin_en,
    input  logic              pin_rd,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    output logic              irq_n
);
    src_vec_t          src;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] mask_q;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(reg_sel);

    always_comb begin
        src = '0;
        src.lvl[B_TX_A]  = tx_lvl_a;
        src.lvl[B_RX_A]  = rx_lvl_a;
        src.lvl[B_TX_B]  = tx_lvl_b;
        src.lvl[B_RX_B]  = rx_lvl_b;
        src.set[B_BRK_A] = brk_evt_a;
        src.clr[B_BRK_A] = brk_clr_a;
        src.set[B_BRK_B] = brk_evt_b;
        src.clr[B_BRK_B] = brk_clr_b;
        src.set[B_CTR]   = ctr_tick;
        src.clr[B_CTR]   = ctr_stop;
        src.set[B_PIN]   = |(pin_chg & pin_en);
        src.clr[B_PIN]   = pin_rd;
    end

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        sio_irq_cell #(.STICKY(is_sticky(i))) cell_i (
            .clk (clk),
            .rst (rst),
            .lvl (src.lvl[i]),
            .set (src.set[i]),
            .clr (src.clr[i]),
            .q   (stat_q[i])
        );
    end

    sio_irq_mask mask_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr && (sel == SEL_MASK)),
        .wdata  (reg_wdata),
        .stat   (stat_q),
        .mask_q (mask_q),
        .irq_n  (irq_n)
    );

    assign reg_rdata = (sel == SEL_STAT) ? stat_q : mask_q;
endmodule

// File: rtl/sio_irq_hub_chk.sv
module sio_irq_hub_chk
    import sio_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tx_lvl_a,
    input logic              brk_evt_a,
    input logic              brk_clr_a,
    input logic              ctr_tick,
    input logic              ctr_stop,
    input logic [PIN_N-1:0]  pin_chg,
    input logic [PIN_N-1:0]  pin_en,
    input logic              pin_rd,
    input logic              reg_sel,
    input logic              reg_wr,
    input logic [STAT_W-1:0] reg_rdata,
    input logic              irq_n,
    input logic [STAT_W-1:0] stat,
    input logic [STAT_W-1:0] mask
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (stat == '0 && mask == '0 && irq_n));

    assert_level_follow_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stat[B_TX_A] == $past(tx_lvl_a)));

    assert_brk_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (stat[B_BRK_A] && !brk_clr_a) |=> stat[B_BRK_A]);

    assert_ctr_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (ctr_stop && !ctr_tick) |=> !stat[B_CTR]);

    assert_pin_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (pin_rd && !(|(pin_chg & pin_en))) |=> !stat[B_PIN]);

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (brk_evt_a && brk_clr_a) |=> stat[B_BRK_A]);

    assert_mask_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> irq_n);

    assert_unmasked_read_R8: assert property (@(posedge clk) disable iff (rst)
        reg_sel |-> (reg_rdata == stat));

    assert_stat_wr_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel) |=> (mask == $past(mask)));
endmodule

bind sio_irq_hub sio_irq_hub_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .tx_lvl_a  (tx_lvl_a),
    .brk_evt_a (brk_evt_a),
    .brk_clr_a (brk_clr_a),
    .ctr_tick  (ctr_tick),
    .ctr_stop  (ctr_stop),
    .pin_chg   (pin_chg),
    .pin_en    (pin_en),
    .pin_rd    (pin_rd),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .irq_n     (irq_n),
    .stat      (stat_q),
    .mask      (mask_q)
);

// File: tb/sio_irq_hub_tb.sv
module sio_irq_hub_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_lvl_a = 0, rx_lvl_a = 0, tx_lvl_b = 0, rx_lvl_b = 0;
    logic       brk_evt_a = 0, brk_evt_b = 0, brk_clr_a = 0, brk_clr_b = 0;
    logic       ctr_tick = 0, ctr_stop = 0, pin_rd = 0;
    logic [3:0] pin_chg = '0, pin_en = '0;
    logic       reg_sel = 1'b1, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_irq_hub dut_i (
        .clk(clk), .rst(rst),
        .tx_lvl_a(tx_lvl_a), .rx_lvl_a(rx_lvl_a),
        .tx_lvl_b(tx_lvl_b), .rx_lvl_b(rx_lvl_b),
        .brk_evt_a(brk_evt_a), .brk_evt_b(brk_evt_b),
        .brk_clr_a(brk_clr_a), .brk_clr_b(brk_clr_b),
        .ctr_tick(ctr_tick), .ctr_stop(ctr_stop),
        .pin_chg(pin_chg), .pin_en(pin_en), .pin_rd(pin_rd),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    // pass one rising edge; inputs change and outputs are sampled at negedge
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic clear_all();
        brk_clr_a = 1; brk_clr_b = 1; ctr_stop = 1; pin_rd = 1;
        tick();
        brk_clr_a = 0; brk_clr_b = 0; ctr_stop = 0; pin_rd = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b1, v); chk("R1 status after reset", v, 8'h00);
        rd(1'b0, v); chk("R1 mask after reset", v, 8'h00);
        chk("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_level();
        logic [7:0] v;
        tx_lvl_a = 1; rx_lvl_b = 1;
        #1; rd(1'b1, v); chk("R2 no change before edge", v, 8'h00);
        tick(); rd(1'b1, v); chk("R2 levels 0x21", v, 8'h21);
        tx_lvl_a = 0; rx_lvl_b = 0; rx_lvl_a = 1; tx_lvl_b = 1;
        tick(); rd(1'b1, v); chk("R2 levels 0x12", v, 8'h12);
        rx_lvl_a = 0; tx_lvl_b = 0;
        tick(); rd(1'b1, v); chk("R2 levels drop", v, 8'h00);
    endtask

    task automatic t_break();
        logic [7:0] v;
        brk_evt_a = 1; tick(); brk_evt_a = 0;
        tick(); tick(); rd(1'b1, v); chk("R3 break A held", v, 8'h04);
        brk_clr_b = 1; tick(); brk_clr_b = 0;
        rd(1'b1, v); chk("R3 clr B leaves A", v, 8'h04);
        brk_clr_a = 1; tick(); brk_clr_a = 0;
        rd(1'b1, v); chk("R3 clr A drops A", v, 8'h00);
        brk_evt_b = 1; tick(); brk_evt_b = 0;
        brk_clr_a = 1; tick(); brk_clr_a = 0;
        rd(1'b1, v); chk("R3 break B held", v, 8'h40);
        brk_clr_b = 1; tick(); brk_clr_b = 0;
        rd(1'b1, v); chk("R3 clr B drops B", v, 8'h00);
    endtask

    task automatic t_counter();
        logic [7:0] v;
        ctr_tick = 1; tick(); ctr_tick = 0;
        tick(); rd(1'b1, v); chk("R4 counter set", v, 8'h08);
        ctr_stop = 1; tick(); ctr_stop = 0;
        rd(1'b1, v); chk("R4 counter stop", v, 8'h00);
    endtask

    task automatic t_pin();
        logic [7:0] v;
        pin_en = 4'b0101;
        pin_chg = 4'b0010; tick(); pin_chg = '0;
        rd(1'b1, v); chk("R5 disabled pin ignored", v, 8'h00);
        pin_chg = 4'b0100; tick(); pin_chg = '0;
        tick(); rd(1'b1, v); chk("R5 enabled pin set", v, 8'h80);
        pin_rd = 1; tick(); pin_rd = 0;
        rd(1'b1, v); chk("R5 read clears", v, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        clear_all();
        brk_evt_a = 1; brk_clr_a = 1; ctr_tick = 1; ctr_stop = 1;
        pin_chg = 4'b0001; pin_rd = 1; brk_evt_b = 1; brk_clr_b = 1;
        tick();
        brk_evt_a = 0; brk_clr_a = 0; ctr_tick = 0; ctr_stop = 0;
        pin_chg = '0; pin_rd = 0; brk_evt_b = 0; brk_clr_b = 0;
        rd(1'b1, v); chk("R6 set beats clear", v, 8'hCC);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        // status now 0xCC
        chk("R7 zero mask keeps irq high", {7'd0, irq_n}, 8'h01);
        reg_sel = 1'b0; reg_wr = 1; reg_wdata = 8'h04; tick(); reg_wr = 0;
        chk("R7 masked bit2 asserts irq", {7'd0, irq_n}, 8'h00);
        rd(1'b0, v); chk("R9 mask loaded", v, 8'h04);
        rd(1'b1, v); chk("R8 status unmasked", v, 8'hCC);
        reg_sel = 1'b0; reg_wr = 1; reg_wdata = 8'h33; tick(); reg_wr = 0;
        chk("R7 non-overlapping mask irq high", {7'd0, irq_n}, 8'h01);
        tx_lvl_b = 1; tick();
        chk("R7 level bit4 asserts irq", {7'd0, irq_n}, 8'h00);
        tx_lvl_b = 0; tick();
        reg_sel = 1'b1; reg_wr = 1; reg_wdata = 8'hFF; tick(); reg_wr = 0;
        rd(1'b1, v); chk("R9 status write ignored", v, 8'hCC);
        rd(1'b0, v); chk("R9 mask untouched", v, 8'h33);
    endtask

    task automatic t_reapply_reset();
        logic [7:0] v;
        rst = 1; tick(); rst = 0;
        rd(1'b1, v); chk("R1 status cleared by reset", v, 8'h00);
        rd(1'b0, v); chk("R1 mask cleared by reset", v, 8'h00);
        chk("R1 irq_n high after reset", {7'd0, irq_n}, 8'h01);
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        t_reset();
        t_level();
        t_break();
        t_counter();
        t_pin();
        t_collide();
        t_mask();
        t_reapply_reset();
        done = 1'b1;
    end

    initial begin : watchdog
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule